// File: doc/BRIEF.md
# Masked Vectored Interrupt Controller

This block collects requests from six interrupt sources: two external pins, three timer/counter events and one serial-port event. Every source owns a pending flag that only hardware can raise and a mask bit. One global enable gates the whole interrupt process. When the enable is on and at least one pending flag has its mask cleared, the block raises a request toward the CPU. With it come the index of the winning source and that source's fixed vector address.

The control bits live at fixed bit positions inside the RAM address space. The CPU's bit-set, bit-clear and bit-test operations reach them through a single-bit access port that takes a word address, a bit number and an operation code. When the CPU acknowledges a request, the global enable drops by itself. The pending flag stays set until software clears it.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the global enable is 0, every pending flag is 0, every mask bit is 1 and `irq_req` is 0.
- R2: A software bit-set aimed at a pending flag leaves it unchanged. A software bit-clear aimed at a pending flag clears it.
- R3: `bit_op` encodes 0 = test, 1 = set, 2 = clear, 3 = no operation. Set and clear act on the enable and mask bits at the clock edge while `bit_en` is 1. `bit_rdata` always shows the bit selected by `bit_addr`/`bit_sel`.
- R4: The global enable is bit 0 of word 0x000. The pending flag of source i is bit i%4 of word 0x001+i/4. The mask of source i is bit i%4 of word 0x020+i/4. Every other bit reads 0 and ignores writes.
- R5: Sources 0 and 1 are asynchronous pins that pass through a two-flop synchronizer. A rising edge sets the flag, which reads 1 three clock edges after the pin is first sampled high and still reads 0 after two edges. A pin held high does not set the flag again after software clears it.
- R6: For sources 2 to 5, a 1 on `src_evt` at a clock edge sets that source's flag at that edge.
- R7: `irq_req` is 1 exactly when the enable is 1 and some source has flag 1 and mask 0.
- R8: Among the eligible sources the lowest index wins. `irq_id` gives that index and `irq_vec` equals 0x0002 + 2*index.
- R9: When `irq_ack` is 1 while `irq_req` is 1, the enable is 0 after that edge and all flags are unchanged. When `irq_ack` is 1 while `irq_req` is 0, nothing changes.
- R10: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | 6 | Source events; bits 0-1 asynchronous pins, bits 2-5 synchronous pulses |
| bit_en | input | 1 | Bit operation valid this cycle |
| bit_op | input | 2 | 0 test, 1 set, 2 clear, 3 none |
| bit_addr | input | 10 | RAM word address of the bit |
| bit_sel | input | 2 | Bit number within the word |
| bit_rdata | output | 1 | Value of the addressed bit |
| irq_ack | input | 1 | CPU accepts the current request |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | 3 | Index of the winning source |
| irq_vec | output | 14 | Vector address of the winning source |

## Verification
A pending flag or mask that is held wrongly shows up at once, in two ways. It appears on `bit_rdata` in the same cycle it is addressed, and it changes `irq_req` or `irq_id` without any delay, because both outputs come from the stored state through combinational logic only. A wrong enable shows at the ports in the cycle after an acknowledge or bit write. The sweep drives every flag pattern against every mask pattern, so a swapped priority or a broken vector stride produces a mismatch on the first affected combination. A synchronizer with the wrong depth moves the flag by one cycle, and the edge-timing checks catch that.

// File: rtl/icu_pkg.sv
package icu_pkg;
   typedef enum logic [1:0] {
      BOP_TEST = 2'd0,
      BOP_SET  = 2'd1,
      BOP_CLR  = 2'd2,
      BOP_NONE = 2'd3
   } bit_op_e;
endpackage

// File: rtl/icu_edge_det.sv
module icu_edge_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("icu_edge_det: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/icu_bitmap.sv
module icu_bitmap
   import icu_pkg::*;
#(
   parameter int N         = 6,
   parameter int ADDR_W    = 10,
   parameter int IE_ADDR   = 0,
   parameter int FLAG_ADDR = 1,
   parameter int MASK_ADDR = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  bit_op_e           bit_op,
   input  logic [ADDR_W-1:0] bit_addr,
   input  logic [1:0]        bit_sel,
   input  logic [N-1:0]      hw_set,
   input  logic              take,
   output logic              ie_q,
   output logic [N-1:0]      flag_q,
   output logic [N-1:0]      mask_q,
   output logic              bit_rdata
);
   logic [N-1:0] flag_hit, mask_hit;
   logic         ie_hit, do_set, do_clr;

   assign ie_hit = (bit_addr == ADDR_W'(IE_ADDR)) && (bit_sel == 2'd0);
   assign do_set = bit_en && (bit_op == BOP_SET);
   assign do_clr = bit_en && (bit_op == BOP_CLR);

   for (genvar i = 0; i < N; i++) begin : g_dec
      assign flag_hit[i] = (bit_addr == ADDR_W'(FLAG_ADDR + i / 4)) && (bit_sel == 2'(i % 4));
      assign mask_hit[i] = (bit_addr == ADDR_W'(MASK_ADDR + i / 4)) && (bit_sel == 2'(i % 4));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q   <= 1'b0;
         flag_q <= '0;
         mask_q <= '1;
      end else begin
         if (take)                  ie_q <= 1'b0;
         else if (ie_hit && do_set) ie_q <= 1'b1;
         else if (ie_hit && do_clr) ie_q <= 1'b0;
         flag_q <= (flag_q & ~(flag_hit & {N{do_clr}})) | hw_set;
         mask_q <= (mask_q | (mask_hit & {N{do_set}})) & ~(mask_hit & {N{do_clr}});
      end
   end

   assign bit_rdata = (ie_hit & ie_q) | (|(flag_hit & flag_q)) | (|(mask_hit & mask_q));
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
   parameter int N        = 6,
   parameter int ID_W     = 3,
   parameter int VEC_W    = 14,
   parameter int VEC_BASE = 2,
   parameter int VEC_STEP = 2
) (
   input  logic [N-1:0]     pend,
   output logic             any,
   output logic [ID_W-1:0]  id,
   output logic [VEC_W-1:0] vec
);
   always_comb begin
      id = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) id = ID_W'(i);
      end
   end

   assign any = |pend;
   assign vec = VEC_W'(VEC_BASE) + VEC_W'(id) * VEC_W'(VEC_STEP);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import icu_pkg::*;
#(
   parameter int NUM_SRC     = 6,
   parameter int NUM_EXT     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 10,
   parameter int IE_ADDR     = 0,
   parameter int FLAG_ADDR   = 1,
   parameter int MASK_ADDR   = 32,
   parameter int VEC_W       = 14,
   parameter int VEC_BASE    = 2,
   parameter int VEC_STEP    = 2,
   localparam int ID_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_evt,
   input  logic               bit_en,
   input  logic [1:0]         bit_op,
   input  logic [ADDR_W-1:0]  bit_addr,
   input  logic [1:0]         bit_sel,
   output logic               bit_rdata,
   input  logic               irq_ack,
   output logic               irq_req,
   output logic [ID_W-1:0]    irq_id,
   output logic [VEC_W-1:0]   irq_vec
);
   initial begin
      if (NUM_SRC < 1 || NUM_SRC > 8) $error("irq_vector_ctrl: NUM_SRC out of range 1..8");
      if (NUM_EXT > NUM_SRC)          $error("irq_vector_ctrl: NUM_EXT exceeds NUM_SRC");
   end

   logic [NUM_SRC-1:0] hw_set, flag_q, mask_q, pend;
   logic               ie_q, take;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (i < NUM_EXT) begin : g_ext
         icu_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk(clk), .rst_n(rst_n), .pin(src_evt[i]), .rise(hw_set[i])
         );
      end else begin : g_int
         assign hw_set[i] = src_evt[i];
      end
   end

   assign take = irq_ack & irq_req;

   icu_bitmap #(
      .N(NUM_SRC), .ADDR_W(ADDR_W), .IE_ADDR(IE_ADDR),
      .FLAG_ADDR(FLAG_ADDR), .MASK_ADDR(MASK_ADDR)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_op(bit_op_e'(bit_op)),
      .bit_addr(bit_addr), .bit_sel(bit_sel), .hw_set(hw_set), .take(take),
      .ie_q(ie_q), .flag_q(flag_q), .mask_q(mask_q), .bit_rdata(bit_rdata)
   );

   assign pend = flag_q & ~mask_q & {NUM_SRC{ie_q}};

   icu_prio #(
      .N(NUM_SRC), .ID_W(ID_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_prio (
      .pend(pend), .any(irq_req), .id(irq_id), .vec(irq_vec)
   );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int N = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_req,
   input logic                irq_ack,
   input logic [$clog2(N)-1:0] irq_id,
   input logic                ie,
   input logic [N-1:0]        flag,
   input logic [N-1:0]        mask,
   input logic [N-1:0]        hw_set
);
   logic [N-1:0] open_src, below_id;
   assign open_src = flag & ~mask;
   assign below_id = N'((1 << irq_id) - 1);

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!ie && flag == '0 && mask == '1)); // R1

   AST_FLAG_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag & ~$past(flag) & ~$past(hw_set)) == '0); // R2

   AST_REQ_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (ie && open_src[irq_id])); // R7

   AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ((open_src & below_id) == '0)); // R8

   AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> (!ie && !irq_req)); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(NUM_SRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack), .irq_id(irq_id),
   .ie(ie_q), .flag(flag_q), .mask(mask_q), .hw_set(hw_set)
);

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  src_evt = '0;
   logic        bit_en = 1'b0;
   logic [1:0]  bit_op = 2'd0;
   logic [9:0]  bit_addr = '0;
   logic [1:0]  bit_sel = '0;
   logic        irq_ack = 1'b0;
   logic        bit_rdata, irq_req;
   logic [2:0]  irq_id;
   logic [13:0] irq_vec;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   irq_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bit_en(bit_en), .bit_op(bit_op),
      .bit_addr(bit_addr), .bit_sel(bit_sel), .bit_rdata(bit_rdata),
      .irq_ack(irq_ack), .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic bop(input int addr, input int sel, input int op);
      bit_addr = 10'(addr); bit_sel = 2'(sel); bit_op = 2'(op); bit_en = 1'b1;
      cyc(1);
      bit_en = 1'b0; bit_op = 2'd0;
   endtask

   task automatic rd(input int addr, input int sel, output int v);
      bit_addr = 10'(addr); bit_sel = 2'(sel); bit_op = 2'd0;
      #1 v = int'(bit_rdata);
   endtask

   function automatic int fa(input int i); return 1 + i / 4; endfunction
   function automatic int ma(input int i); return 32 + i / 4; endfunction

   task automatic raise(input int i);
      if (i < 2) begin
         src_evt[i] = 1'b1; cyc(4); src_evt[i] = 1'b0; cyc(3);
      end else begin
         src_evt[i] = 1'b1; cyc(1); src_evt[i] = 1'b0;
      end
   endtask

   initial begin
      #(20 * 190000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v, low;
      bit exp_req;
      cyc(3);
      rst_n = 1'b1;
      // R1: reset values
      rd(0, 0, v); chk("R1 enable", v, 0);
      for (int i = 0; i < 6; i++) begin
         rd(fa(i), i % 4, v); chk("R1 flag", v, 0);
         rd(ma(i), i % 4, v); chk("R1 mask", v, 1);
      end
      chk("R1 irq_req", int'(irq_req), 0);

      // R2: software set of flag ignored; clear works
      for (int i = 0; i < 6; i++) begin
         bop(fa(i), i % 4, 1); rd(fa(i), i % 4, v); chk("R2 sw set ignored", v, 0);
      end
      raise(3); rd(fa(3), 3, v); chk("R6 flag3 set", v, 1);
      bop(fa(3), 3, 2); rd(fa(3), 3, v); chk("R2 sw clear", v, 0);

      // R3: enable/mask set, clear, and no-op code
      bop(0, 0, 1); rd(0, 0, v); chk("R3 ie set", v, 1);
      bop(0, 0, 3); rd(0, 0, v); chk("R3 op none keeps ie", v, 1);
      bop(0, 0, 2); rd(0, 0, v); chk("R3 ie clear", v, 0);
      bop(ma(5), 1, 2); rd(ma(5), 1, v); chk("R3 mask clear", v, 0);
      bop(ma(5), 1, 0); rd(ma(5), 1, v); chk("R3 test no change", v, 0);
      bop(ma(5), 1, 1); rd(ma(5), 1, v); chk("R3 mask set", v, 1);

      // R4: unmapped bits read 0 and ignore writes
      bop(0, 1, 1);  rd(0, 1, v);  chk("R4 word0 bit1", v, 0);
      bop(3, 0, 1);  rd(3, 0, v);  chk("R4 word3 bit0", v, 0);
      bop(2, 2, 1);  rd(2, 2, v);  chk("R4 flag word bit2", v, 0);
      bop(33, 3, 1); rd(33, 3, v); chk("R4 mask word bit3", v, 0);
      rd(0, 0, v); chk("R4 ie untouched", v, 0);

      // R5: two-flop synchronizer latency and single set on held level
      src_evt[1] = 1'b1;
      cyc(2); rd(fa(1), 1, v); chk("R5 not yet after two edges", v, 0);
      cyc(1); rd(fa(1), 1, v); chk("R5 set after three edges", v, 1);
      bop(fa(1), 1, 2); cyc(5);
      rd(fa(1), 1, v); chk("R5 held level no reset", v, 0);
      src_evt[1] = 1'b0; cyc(4);

      // R6 and R10: hardware set beats software clear
      raise(4); rd(fa(4), 0, v); chk("R6 flag4 set", v, 1);
      bit_addr = 10'(fa(4)); bit_sel = 2'd0; bit_op = 2'd2; bit_en = 1'b1; src_evt[4] = 1'b1;
      cyc(1);
      bit_en = 1'b0; src_evt[4] = 1'b0; bit_op = 2'd0;
      rd(fa(4), 0, v); chk("R10 hw set wins", v, 1);
      bop(fa(4), 0, 2);

      // R7/R8: sweep of all flag patterns against all mask patterns
      bop(0, 0, 1);
      for (int f = 0; f < 64; f++) begin
         for (int i = 0; i < 6; i++) bop(fa(i), i % 4, 2);
         for (int i = 0; i < 6; i++) if (f[i]) raise(i);
         for (int m = 0; m < 64; m++) begin
            for (int i = 0; i < 6; i++) bop(ma(i), i % 4, m[i] ? 1 : 2);
            exp_req = ((f & ~m & 63) != 0);
            low = 0;
            for (int i = 5; i >= 0; i--) if (f[i] && !m[i]) low = i;
            chk("R7 irq_req", int'(irq_req), int'(exp_req));
            if (exp_req) begin
               chk("R8 irq_id", int'(irq_id), low);
               chk("R8 irq_vec", int'(irq_vec), 2 + 2 * low);
            end
         end
      end
      // state: flags all 1, masks all 1 (m=63), ie=1
      bop(0, 0, 2); bop(ma(2), 2, 2);
      chk("R7 enable off blocks", int'(irq_req), 0);

      // R9: acknowledge
      bop(0, 0, 1);
      chk("R8 single open id", int'(irq_id), 2);
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
      rd(0, 0, v); chk("R9 ie cleared on ack", v, 0);
      chk("R9 req dropped", int'(irq_req), 0);
      rd(fa(2), 2, v); chk("R9 flag kept", v, 1);
      bop(ma(2), 2, 1); bop(0, 0, 1);
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
      rd(0, 0, v); chk("R9 ack without req ignored", v, 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule